// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital control core of a 16-bit successive-approximation converter. Two active-low controls, a chip-select and a read/convert line, decide when a conversion begins. The start is level-sensitive: a conversion begins on the first clock edge at which both lines are low while the block is idle. During a conversion the block drives a trial code to an external capacitor DAC. It samples a one-bit comparator once per clock and resolves one bit per cycle, starting from the most significant bit. A busy flag, active low, covers the whole conversion.

At the end of a conversion the result goes into an output register. The result is read through an 8-bit parallel bus in two halves, and a byte-select input picks the half. A format input selects straight binary or two's complement coding. The bus drives only while chip-select is low and read/convert is high, and it is released otherwise. If both controls are still low when busy returns high, a new conversion starts immediately. That result carries a cleared freshness flag, because the input had no time to be acquired.

Top module: `sar_conv_ctrl`

## Requirements
- R1: With busy high, a conversion starts at the first clock edge where `cs_n` and `rc_n` are both low. Either line may be the one that falls last. `busy` reads low in the following cycle.
- R2: `busy` stays low for exactly 16 clock cycles. It returns high on the same edge that loads the new result into the output register.
- R3: While `busy` is low, any activity on `cs_n` and `rc_n` is ignored. The conversion length and its result are unchanged.
- R4: If `cs_n` and `rc_n` are both low in the first cycle that `busy` is high again, a new conversion starts on the next edge, and its result is stored with `result_fresh` = 0. A conversion started from an idle cycle that did not directly follow a conversion stores `result_fresh` = 1.
- R5: With `fmt_sb` = 1 the result is presented as straight binary. With `fmt_sb` = 0 it is two's complement, which equals the straight binary code with bit 15 inverted.
- R6: `dbus` carries result bits 15..8 when `byte_sel` = 0 and bits 7..0 when `byte_sel` = 1.
- R7: `dbus` is driven, with `dbus_en` = 1, only while `cs_n` = 0 and `rc_n` = 1. In every other case it is high-impedance and `dbus_en` = 0.
- R8: Reading the bus, whether by toggling `byte_sel`, `fmt_sb` or the enable condition, never changes the stored result.
- R9: The trial code on `dac_code` is 0x8000 in the first conversion cycle. Each cycle keeps the trial bit when `cmp_in` = 1 (analog input at or above the trial code), clears it otherwise, and sets the next lower bit. The stored result is the largest code not above the analog input.
- R10: After reset `busy` = 1, the stored result is 0 and `result_fresh` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rc_n | input | 1 | Read (high) / convert (low) control |
| fmt_sb | input | 1 | 1 = straight binary, 0 = two's complement |
| byte_sel | input | 1 | 0 = upper byte, 1 = lower byte on the bus |
| cmp_in | input | 1 | Comparator: 1 when the analog input is at or above the trial code |
| busy | output | 1 | Low while a conversion runs |
| dac_code | output | 16 | Trial code driven to the DAC |
| dbus | output | 8 | Parallel result byte, high-impedance when not enabled |
| dbus_en | output | 1 | High while dbus is driven |
| result_fresh | output | 1 | Stored result followed a proper acquisition |

## Verification
The bench starts conversions with each control line falling last. It counts the busy-low cycles, so a controller that is off by one in its bit counter reports 15 or 17. Control lines are pulsed in the middle of a conversion, so a design that re-arms while busy would restart and lose the result. The back-to-back case holds both lines low through the busy rise. A design that waits for a fresh falling edge would stay idle, and one without the acquisition check would report the result as fresh. Codes at both ends of the range and alternating bit patterns expose a wrong keep/clear decision, and repeated reads with the format flipped would show any read that disturbed the stored code.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;
  localparam int unsigned DEF_BUS_W = 8;

  typedef enum logic [0:0] {
    SAR_IDLE = 1'b0,
    SAR_STEP = 1'b1
  } sar_state_e;
endpackage

// File: rtl/sar_start_ctl.sv
module sar_start_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rc_n,
  input  logic conv_done,
  output logic busy,
  output logic start_pulse,
  output logic conv_short
);
  logic busy_q;
  logic just_done_q;
  logic short_q;
  logic start_req;

  // both lines low: the OR of the active-low controls is low
  assign start_req   = ~(cs_n | rc_n);
  assign start_pulse = busy_q & start_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b1;
      just_done_q <= 1'b0;
      short_q     <= 1'b0;
    end else begin
      just_done_q <= conv_done;
      if (start_pulse) begin
        busy_q  <= 1'b0;
        short_q <= just_done_q;
      end else if (conv_done) begin
        busy_q <= 1'b1;
      end
    end
  end

  assign busy       = busy_q;
  assign conv_short = short_q;
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int unsigned CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cmp_in,
  output logic [CODE_W-1:0] trial,
  output logic              conv_done,
  output logic [CODE_W-1:0] result
);
  import sar_ctl_pkg::*;

  localparam int unsigned IDX_W = $clog2(CODE_W);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(CODE_W - 1);
  localparam logic [CODE_W-1:0] FIRST_TRIAL = {1'b1, {(CODE_W-1){1'b0}}};

  sar_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CODE_W-1:0] trial_q;
  logic [CODE_W-1:0] next_trial;

  // resolve bit k from the comparator and arm bit k-1
  function automatic logic [CODE_W-1:0] sar_step(
    input logic [CODE_W-1:0] t,
    input logic [IDX_W-1:0]  k,
    input logic              keep
  );
    logic [CODE_W-1:0] r;
    r    = t;
    r[k] = keep;
    if (k != '0) r[k - 1'b1] = 1'b1;
    return r;
  endfunction

  assign next_trial = sar_step(trial_q, idx_q, cmp_in);
  assign conv_done  = (state_q == SAR_STEP) && (idx_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SAR_IDLE;
      idx_q   <= '0;
      trial_q <= '0;
    end else if (start) begin
      state_q <= SAR_STEP;
      idx_q   <= TOP_IDX;
      trial_q <= FIRST_TRIAL;
    end else if (state_q == SAR_STEP) begin
      trial_q <= next_trial;
      idx_q   <= idx_q - 1'b1;
      if (idx_q == '0) state_q <= SAR_IDLE;
    end
  end

  assign trial  = trial_q;
  assign result = next_trial;
endmodule

// File: rtl/sar_out_reg.sv
module sar_out_reg #(
  parameter int unsigned BUS_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [2*BUS_W-1:0] load_val,
  input  logic               load_fresh,
  input  logic               fmt_sb,
  input  logic               byte_sel,
  input  logic               cs_n,
  input  logic               rc_n,
  output logic [BUS_W-1:0]   dbus,
  output logic               dbus_en,
  output logic               fresh,
  output logic [2*BUS_W-1:0] code
);
  localparam int unsigned CODE_W = 2 * BUS_W;

  logic [CODE_W-1:0] code_q;
  logic              fresh_q;
  logic [CODE_W-1:0] shown;
  logic [BUS_W-1:0]  byte_val;

  // two's complement view of an offset-binary code: flip the sign bit
  function automatic logic [CODE_W-1:0] fmt_code(
    input logic [CODE_W-1:0] sb,
    input logic              straight
  );
    return straight ? sb : {~sb[CODE_W-1], sb[CODE_W-2:0]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      fresh_q <= 1'b0;
    end else if (load) begin
      code_q  <= load_val;
      fresh_q <= load_fresh;
    end
  end

  assign shown    = fmt_code(code_q, fmt_sb);
  assign byte_val = byte_sel ? shown[BUS_W-1:0] : shown[CODE_W-1:BUS_W];
  assign dbus_en  = ~cs_n & rc_n;
  assign dbus     = dbus_en ? byte_val : {BUS_W{1'bz}};
  assign fresh    = fresh_q;
  assign code     = code_q;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int unsigned BUS_W = sar_ctl_pkg::DEF_BUS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               rc_n,
  input  logic               fmt_sb,
  input  logic               byte_sel,
  input  logic               cmp_in,
  output logic               busy,
  output logic [2*BUS_W-1:0] dac_code,
  output logic [BUS_W-1:0]   dbus,
  output logic               dbus_en,
  output logic               result_fresh
);
  localparam int unsigned CODE_W = 2 * BUS_W;

  // named internal events, observed by the bound checker
  logic              start_pulse;
  logic              conv_done;
  logic              conv_short;
  logic [CODE_W-1:0] sar_result;
  logic [CODE_W-1:0] out_code;

  sar_start_ctl u_start (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .rc_n        (rc_n),
    .conv_done   (conv_done),
    .busy        (busy),
    .start_pulse (start_pulse),
    .conv_short  (conv_short)
  );

  sar_approx #(.CODE_W(CODE_W)) u_sar (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_pulse),
    .cmp_in    (cmp_in),
    .trial     (dac_code),
    .conv_done (conv_done),
    .result    (sar_result)
  );

  sar_out_reg #(.BUS_W(BUS_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (conv_done),
    .load_val   (sar_result),
    .load_fresh (~conv_short),
    .fmt_sb     (fmt_sb),
    .byte_sel   (byte_sel),
    .cs_n       (cs_n),
    .rc_n       (rc_n),
    .dbus       (dbus),
    .dbus_en    (dbus_en),
    .fresh      (result_fresh),
    .code       (out_code)
  );
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int unsigned CODE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              rc_n,
  input logic              busy,
  input logic              dbus_en,
  input logic              start_pulse,
  input logic              conv_done,
  input logic [CODE_W-1:0] dac_code,
  input logic [CODE_W-1:0] out_code
);
  localparam int unsigned CNT_W = $clog2(CODE_W + 2);

  logic [CNT_W-1:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lo_cnt <= '0;
    else if (busy) lo_cnt <= '0;
    else           lo_cnt <= lo_cnt + 1'b1;
  end

  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cs_n && !rc_n) |=> !busy); // R1
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (lo_cnt == CNT_W'(CODE_W))); // R2
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !conv_done) |=> !busy); // R3
  AST_REARM_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !cs_n && !rc_n) |=> !busy); // R4
  AST_BUS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !rc_n) |-> !dbus_en); // R7
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(out_code)); // R8
  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> (dac_code == {1'b1, {(CODE_W-1){1'b0}}})); // R9
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.CODE_W(2*BUS_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .rc_n        (rc_n),
  .busy        (busy),
  .dbus_en     (dbus_en),
  .start_pulse (start_pulse),
  .conv_done   (conv_done),
  .dac_code    (dac_code),
  .out_code    (out_code)
);

// File: tb/test_sar_conv_ctrl.sv
module test_sar_conv_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        rc_n = 1'b1;
  logic        fmt_sb = 1'b1;
  logic        byte_sel = 1'b0;
  logic        cmp_in;
  logic        busy;
  logic [15:0] dac_code;
  logic [7:0]  dbus;
  logic        dbus_en;
  logic        result_fresh;
  logic [15:0] vin_m = 16'h0000;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  // ideal comparator: high when the analog input is at or above the trial
  assign cmp_in = (vin_m >= dac_code);

  sar_conv_ctrl i_sar_conv_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rc_n(rc_n), .fmt_sb(fmt_sb),
    .byte_sel(byte_sel), .cmp_in(cmp_in), .busy(busy), .dac_code(dac_code),
    .dbus(dbus), .dbus_en(dbus_en), .result_fresh(result_fresh)
  );

  // {analog input, straight-binary flag}
  localparam logic [16:0] VEC [0:9] = '{
    {16'h0000, 1'b1}, {16'hFFFF, 1'b1}, {16'h8000, 1'b0}, {16'h7FFF, 1'b0},
    {16'hAAAA, 1'b1}, {16'h5555, 1'b0}, {16'h0001, 1'b0}, {16'h1234, 1'b1},
    {16'hFFFE, 1'b0}, {16'hC3A5, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_view(input logic [15:0] v, input logic sb);
    return sb ? v : v + 16'h8000;
  endfunction

  // start a conversion; returns busy-low cycle count and first trial code
  task automatic convert(input logic [15:0] v, input bit rc_last,
                         output int lo, output logic [15:0] first_dac);
    vin_m = v;
    @(negedge clk);
    if (rc_last) begin cs_n = 1'b0; rc_n = 1'b1; end
    else         begin cs_n = 1'b1; rc_n = 1'b0; end
    @(negedge clk);
    if (rc_last) rc_n = 1'b0; else cs_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; rc_n = 1'b1;
    first_dac = dac_code;
    lo = 0;
    while (!busy && lo < 40) begin
      lo++;
      @(negedge clk);
    end
  endtask

  task automatic read_word(input logic sb, output logic [15:0] w, output logic en);
    fmt_sb = sb; cs_n = 1'b0; rc_n = 1'b1;
    byte_sel = 1'b0; #2; w[15:8] = dbus; en = dbus_en;
    byte_sel = 1'b1; #2; w[7:0] = dbus; en = en & dbus_en;
    cs_n = 1'b1; #1;
  endtask

  initial begin
    int lo;
    logic [15:0] fd;
    logic [15:0] w;
    logic en;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 busy after reset", 32'(busy), 32'd1);
    chk("R10 fresh after reset", 32'(result_fresh), 32'd0);
    read_word(1'b1, w, en);
    chk("R10 stored zero", 32'(w), 32'h0000);
    read_word(1'b0, w, en);
    chk("R5 zero as twos complement", 32'(w), 32'h8000);
    chk("R7 bus enabled on read", 32'(en), 32'd1);

    for (int i = 0; i < 10; i++) begin
      convert(VEC[i][16:1], i[0], lo, fd);
      chk("R1 R2 busy low cycles", 32'(lo), 32'd16);
      chk("R9 first trial", 32'(fd), 32'h8000);
      chk("R4 fresh after acquisition", 32'(result_fresh), 32'd1);
      read_word(VEC[i][0], w, en);
      chk("R5 R6 R9 result bytes", 32'(w), 32'(expect_view(VEC[i][16:1], VEC[i][0])));
      chk("R7 bus driven", 32'(en), 32'd1);
      cs_n = 1'b1; rc_n = 1'b1; #1;
      chk("R7 released, cs high", 32'(dbus_en), 32'd0);
    end

    // R7: read/convert low with chip select high also releases the bus
    cs_n = 1'b1; rc_n = 1'b0; #2;
    chk("R7 released, rc low", 32'(dbus_en), 32'd0);
    rc_n = 1'b1;

    // R8: many reads leave the stored result untouched
    for (int k = 0; k < 4; k++) read_word(k[0], w, en);
    read_word(1'b1, w, en);
    chk("R8 stored value kept", 32'(w), 32'hC3A5);

    // R3: control activity during a conversion is ignored
    vin_m = 16'h3C5A;
    @(negedge clk); cs_n = 1'b0; rc_n = 1'b0;
    @(negedge clk); cs_n = 1'b1; rc_n = 1'b1;
    lo = 1;
    repeat (3) begin @(negedge clk); lo++; end
    cs_n = 1'b0; rc_n = 1'b0;
    @(negedge clk); lo++; rc_n = 1'b1;
    @(negedge clk); lo++; rc_n = 1'b0;
    @(negedge clk); lo++; cs_n = 1'b1;
    @(negedge clk); lo++; rc_n = 1'b1;
    while (!busy && lo < 40) begin @(negedge clk); lo++; end
    chk("R3 length unchanged", 32'(lo - 1), 32'd16);
    read_word(1'b1, w, en);
    chk("R3 result unchanged", 32'(w), 32'h3C5A);

    // R4: both lines held low across the busy rise
    vin_m = 16'h0F0F;
    repeat (2) @(negedge clk);
    cs_n = 1'b0; rc_n = 1'b0;
    @(negedge clk);
    lo = 0;
    while (!busy && lo < 40) begin lo++; @(negedge clk); end
    chk("R4 first run length", 32'(lo), 32'd16);
    chk("R4 first run fresh", 32'(result_fresh), 32'd1);
    @(negedge clk);
    chk("R4 immediate restart", 32'(busy), 32'd0);
    cs_n = 1'b1; rc_n = 1'b1;
    lo = 0;
    while (!busy && lo < 40) begin lo++; @(negedge clk); end
    chk("R4 short result flagged", 32'(result_fresh), 32'd0);
    convert(16'h0F0F, 1'b0, lo, fd);
    chk("R4 fresh restored", 32'(result_fresh), 32'd1);

    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule